// File: doc/BRIEF.md
# Serial Control Register Bank with Page-Memory Window

This block is the register file that sits behind a two-wire serial slave. The bit-level bus engine is outside it and hands over whole bytes as single-cycle strobes. A write transaction begins with a subaddress byte that loads a register pointer. Every data byte after that, read or written, uses the register the pointer names and then moves the pointer on by one.

Addresses 0 to 10 hold control registers. Software can write them but cannot read them back, and their contents go to the rest of the chip on a flat configuration bus. Address 11 is shared. A select bit in register 0 decides what it reaches. With the bit clear, address 11 is a read/write window into page memory. The memory address comes from the chapter, row and column fields of registers 8, 9 and 10, and the column steps forward after every access. With the bit set, address 11 is a read-only status byte, captured when a read transaction begins.

Top module: `ctl_regbank`

## Requirements
- R1: After reset, registers 5 and 6 hold 0x03 and every other control register (0 to 4 and 7 to 10) holds 0x00.
- R2: The first byte written after a write start loads the pointer. A value above 11 leaves the pointer unchanged, and the next data byte goes to the register the pointer already held.
- R3: Each data byte, written or read, advances the pointer by one. After address 11 the pointer returns to 0.
- R4: A data byte written to addresses 0 to 10 is stored in full, and the register appears at byte lane `8*addr` of `cfg_regs`. Reading any of these addresses returns 0xFF.
- R5: Bit 7 of register 0 chooses what address 11 reaches: 0 selects the memory window and 1 selects the status byte.
- R6: The window address is {reg8[2:0], reg9[4:0], reg10[5:0]}, with the chapter in bits 13..11, the row in bits 10..6 and the column in bits 5..0. A window write raises `mem_we` for one cycle and drives the data byte on `mem_wdata`. A window read raises `mem_re` for one cycle and returns `mem_rdata` on `rd_byte`. `mem_we` and `mem_re` are never high together.
- R7: Every window access adds one to the column. When the column is at 39, it goes to 0 and the row (5 bits, modulo 32) goes up by one. The upper bits of registers 9 and 10 are not changed.
- R8: The status byte is bit 7 = 60 Hz flag, bits 6..2 = 0, bit 1 = data quality, bit 0 = sync quality. It is captured on the start of a read transaction and does not change until the next start.
- R9: A byte written to address 11 while status is selected produces no memory write and leaves the column and row unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Pulse marking the start of a transaction |
| bus_rd | input | 1 | Direction of the transaction being started (1 = read) |
| wr_strobe | input | 1 | A byte has arrived from the bus master |
| wr_byte | input | 8 | Byte received from the master |
| rd_strobe | input | 1 | The master has taken the byte on rd_byte |
| rd_byte | output | 8 | Byte offered to the master at the current pointer |
| st_60hz | input | 1 | 60 Hz field-rate flag |
| st_data_ok | input | 1 | Data quality flag |
| st_sync_ok | input | 1 | Video sync quality flag |
| mem_addr | output | 14 | Page memory address (chapter, row, column) |
| mem_wdata | output | 8 | Page memory write data |
| mem_we | output | 1 | Page memory write strobe |
| mem_re | output | 1 | Page memory read strobe |
| mem_rdata | input | 8 | Page memory read data for mem_addr |
| cfg_regs | output | 88 | Control registers 0 to 10, register n at bits 8n+7..8n |

## Verification
The bench builds the block with its default parameters: eight-bit registers, a 3/5/6-bit chapter, row and column split, and a last column of 39. With these values the column wrap is reached by loading the column register with 39 directly, with no long run of accesses before it. The pointer wrap from 11 to 0 is reached after a single window byte. The bench's memory model returns a byte computed from the address, so every window read also checks how the chapter, row and column fields are placed in the address.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;
  parameter int REG_W    = 8;
  parameter int NUM_CTL  = 11;   // control registers below the window address
  parameter int WIN_ADDR = NUM_CTL;
  parameter int PTR_W    = $clog2(NUM_CTL + 1);
  parameter int MODE_REG = 0;
  parameter int SEL_BIT  = 7;
  parameter int CHAP_REG = 8;
  parameter int ROW_REG  = 9;
  parameter int COL_REG  = 10;

  function automatic logic [REG_W-1:0] reset_value(input int idx);
    return (idx == 5 || idx == 6) ? REG_W'(3) : '0;
  endfunction
endpackage

// File: rtl/ctl_ptr.sv
module ctl_ptr
  import ctl_regbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_start,
  input  logic             bus_rd,
  input  logic             wr_strobe,
  input  logic [REG_W-1:0] wr_byte,
  input  logic             rd_strobe,
  output logic [PTR_W-1:0] ptr,
  output logic             data_wr,
  output logic             data_rd
);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(WIN_ADDR);

  logic             want_sub_q, want_sub_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;

  assign data_wr = wr_strobe && !want_sub_q && !bus_start;
  assign data_rd = rd_strobe && !wr_strobe && !bus_start;

  always_comb begin
    want_sub_d = want_sub_q;
    ptr_d      = ptr_q;
    if (bus_start) begin
      want_sub_d = !bus_rd;
    end else if (wr_strobe && want_sub_q) begin
      want_sub_d = 1'b0;
      if (int'(wr_byte) <= WIN_ADDR) ptr_d = wr_byte[PTR_W-1:0];
    end else if (data_wr || data_rd) begin
      ptr_d = (ptr_q == LAST_P) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_sub_q <= 1'b0;
      ptr_q      <= '0;
    end else begin
      want_sub_q <= want_sub_d;
      ptr_q      <= ptr_d;
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import ctl_regbank_pkg::*;
#(
  parameter int CHAP_W   = 3,
  parameter int ROW_W    = 5,
  parameter int COL_W    = 6,
  parameter int LAST_COL = 39
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [PTR_W-1:0]         waddr,
  input  logic [REG_W-1:0]         wdata,
  input  logic                     col_step,
  output logic [NUM_CTL*REG_W-1:0] regs
);
  localparam logic [COL_W-1:0] LAST_C = COL_W'(LAST_COL);

  logic [REG_W-1:0] q [NUM_CTL];
  logic [COL_W-1:0] col_cur;
  logic             col_last;

  assign col_cur  = q[COL_REG][COL_W-1:0];
  assign col_last = (col_cur == LAST_C);

  for (genvar g = 0; g < NUM_CTL; g++) begin : g_reg
    logic [REG_W-1:0] d;

    always_comb begin
      d = q[g];
      if (wr_en && waddr == PTR_W'(g)) d = wdata;
      if (col_step) begin
        if (g == COL_REG)
          d = {q[g][REG_W-1:COL_W], col_last ? {COL_W{1'b0}} : col_cur + 1'b1};
        if (g == ROW_REG && col_last)
          d = {q[g][REG_W-1:ROW_W], q[g][ROW_W-1:0] + 1'b1};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[g] <= reset_value(g);
      else        q[g] <= d;
    end

    assign regs[g*REG_W +: REG_W] = q[g];
  end
endmodule

// File: rtl/ctl_stat_snap.sv
module ctl_stat_snap
  import ctl_regbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             st_60hz,
  input  logic             st_data_ok,
  input  logic             st_sync_ok,
  output logic [REG_W-1:0] stat
);
  logic [REG_W-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (capture) begin
      stat_d                = '0;
      stat_d[REG_W-1]       = st_60hz;
      stat_d[1]             = st_data_ok;
      stat_d[0]             = st_sync_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat = stat_q;
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_regbank_pkg::*;
#(
  parameter int CHAP_W   = 3,
  parameter int ROW_W    = 5,
  parameter int COL_W    = 6,
  parameter int LAST_COL = 39,
  localparam int ADDR_W  = CHAP_W + ROW_W + COL_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_start,
  input  logic                     bus_rd,
  input  logic                     wr_strobe,
  input  logic [REG_W-1:0]         wr_byte,
  input  logic                     rd_strobe,
  output logic [REG_W-1:0]         rd_byte,
  input  logic                     st_60hz,
  input  logic                     st_data_ok,
  input  logic                     st_sync_ok,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [REG_W-1:0]         mem_wdata,
  output logic                     mem_we,
  output logic                     mem_re,
  input  logic [REG_W-1:0]         mem_rdata,
  output logic [NUM_CTL*REG_W-1:0] cfg_regs
);
  localparam logic [PTR_W-1:0] WIN_P = PTR_W'(WIN_ADDR);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [PTR_W-1:0] ptr;
  logic             data_wr, data_rd;
  logic [REG_W-1:0] stat_q;
  logic             sel_stat, at_win, win_act;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic [CHAP_W-1:0] chap;

  ctl_ptr u_ptr (
    .clk(clk), .rst_n(rst_n_s), .bus_start(bus_start), .bus_rd(bus_rd),
    .wr_strobe(wr_strobe), .wr_byte(wr_byte), .rd_strobe(rd_strobe),
    .ptr(ptr), .data_wr(data_wr), .data_rd(data_rd)
  );

  ctl_stat_snap u_stat (
    .clk(clk), .rst_n(rst_n_s), .capture(bus_start && bus_rd),
    .st_60hz(st_60hz), .st_data_ok(st_data_ok), .st_sync_ok(st_sync_ok),
    .stat(stat_q)
  );

  ctl_regfile #(
    .CHAP_W(CHAP_W), .ROW_W(ROW_W), .COL_W(COL_W), .LAST_COL(LAST_COL)
  ) u_rf (
    .clk(clk), .rst_n(rst_n_s), .wr_en(data_wr), .waddr(ptr), .wdata(wr_byte),
    .col_step(win_act), .regs(cfg_regs)
  );

  assign sel_stat = cfg_regs[MODE_REG*REG_W + SEL_BIT];
  assign at_win   = (ptr == WIN_P);
  assign chap     = cfg_regs[CHAP_REG*REG_W +: CHAP_W];
  assign row      = cfg_regs[ROW_REG*REG_W  +: ROW_W];
  assign col      = cfg_regs[COL_REG*REG_W  +: COL_W];

  assign mem_addr  = {chap, row, col};
  assign mem_wdata = wr_byte;
  assign mem_we    = data_wr && at_win && !sel_stat;
  assign mem_re    = data_rd && at_win && !sel_stat;
  assign win_act   = mem_we || mem_re;

  always_comb begin
    if (!at_win)      rd_byte = '1;
    else if (sel_stat) rd_byte = stat_q;
    else              rd_byte = mem_rdata;
  end
endmodule

// File: rtl/ctl_regbank_chk.sv
module ctl_regbank_chk
  import ctl_regbank_pkg::*;
#(
  parameter int ROW_W    = 5,
  parameter int COL_W    = 6,
  parameter int LAST_COL = 39
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PTR_W-1:0] ptr,
  input logic             data_wr,
  input logic             data_rd,
  input logic             bus_start,
  input logic             sel_stat,
  input logic [REG_W-1:0] rd_byte,
  input logic [REG_W-1:0] stat_q,
  input logic             mem_we,
  input logic             mem_re,
  input logic [COL_W-1:0] col,
  input logic [ROW_W-1:0] row
);
  localparam logic [PTR_W-1:0] WIN_P  = PTR_W'(WIN_ADDR);
  localparam logic [COL_W-1:0] LAST_C = COL_W'(LAST_COL);

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr || data_rd) && ptr == WIN_P |=> ptr == '0); // R3

  AST_WO_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    ptr != WIN_P |-> rd_byte == '1); // R4

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R6

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) && col != LAST_C |=> col == $past(col) + 1'b1 && $stable(row)); // R7

  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) && col == LAST_C |=> col == '0 && row == $past(row) + 1'b1); // R7

  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_start |=> $stable(stat_q)); // R8

  AST_STAT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    ptr == WIN_P && sel_stat |-> rd_byte[6:2] == '0); // R8

  AST_STAT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    ptr == WIN_P && sel_stat |-> !mem_we && !mem_re); // R9
endmodule

bind ctl_regbank ctl_regbank_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .LAST_COL(LAST_COL)
) u_chk (
  .clk(clk), .rst_n(rst_n_s), .ptr(ptr), .data_wr(data_wr), .data_rd(data_rd),
  .bus_start(bus_start), .sel_stat(sel_stat), .rd_byte(rd_byte), .stat_q(stat_q),
  .mem_we(mem_we), .mem_re(mem_re), .col(col), .row(row)
);

// File: tb/ctl_regbank_tb.sv
module ctl_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_start = 1'b0, bus_rd = 1'b0;
  logic        wr_strobe = 1'b0, rd_strobe = 1'b0;
  logic [7:0]  wr_byte = 8'h00;
  logic [7:0]  rd_byte;
  logic        st_60hz = 1'b0, st_data_ok = 1'b0, st_sync_ok = 1'b0;
  logic [13:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_we, mem_re;
  logic [87:0] cfg_regs;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;   // 250 MHz

  function automatic logic [7:0] mem_model(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b01};
  endfunction
  assign mem_rdata = mem_model(mem_addr);

  ctl_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_rd(bus_rd),
    .wr_strobe(wr_strobe), .wr_byte(wr_byte), .rd_strobe(rd_strobe), .rd_byte(rd_byte),
    .st_60hz(st_60hz), .st_data_ok(st_data_ok), .st_sync_ok(st_sync_ok),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .cfg_regs(cfg_regs)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_of(input int i);
    return cfg_regs[i*8 +: 8];
  endfunction

  // all drives happen after a falling edge; samples are taken before the next rising edge
  task automatic start(input logic rd);
    @(negedge clk); bus_start = 1'b1; bus_rd = rd;
    @(negedge clk); bus_start = 1'b0; bus_rd = 1'b0;
  endtask

  logic        s_we, s_re;
  logic [13:0] s_addr;
  logic [7:0]  s_wdata, s_rd;

  task automatic wbyte(input logic [7:0] b);
    wr_strobe = 1'b1; wr_byte = b;
    #1; s_we = mem_we; s_addr = mem_addr; s_wdata = mem_wdata;
    @(negedge clk); wr_strobe = 1'b0;
  endtask

  task automatic rbyte();
    rd_strobe = 1'b1;
    #1; s_re = mem_re; s_addr = mem_addr; s_rd = rd_byte;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  // vectors: {subaddress, data}
  localparam logic [15:0] VEC [6] = '{
    {8'd1, 8'h3C}, {8'd2, 8'h07}, {8'd3, 8'h15},
    {8'd4, 8'h02}, {8'd7, 8'hE1}, {8'd0, 8'h41}
  };

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values
    for (int i = 0; i < 11; i++)
      check("R1 reset value", reg_of(i), (i == 5 || i == 6) ? 32'h03 : 32'h00);

    // R4: table of writes, each then read back as 0xFF
    for (int v = 0; v < 6; v++) begin
      start(1'b0); wbyte(VEC[v][15:8]); wbyte(VEC[v][7:0]);
      check("R4 stored byte", reg_of(int'(VEC[v][15:8])), VEC[v][7:0]);
      start(1'b0); wbyte(VEC[v][15:8]);
      start(1'b1); rbyte();
      check("R4 write-only reads 0xFF", s_rd, 8'hFF);
    end

    // R3: burst of writes from 3 lands on 3,4,5
    start(1'b0); wbyte(8'd3); wbyte(8'hA1); wbyte(8'hA2); wbyte(8'hA3);
    check("R3 burst r3", reg_of(3), 8'hA1);
    check("R3 burst r4", reg_of(4), 8'hA2);
    check("R3 burst r5", reg_of(5), 8'hA3);

    // R6/R7/R3: set chapter 5, row 3, column 39, then a window write, then wrap to reg 0
    start(1'b0); wbyte(8'd8); wbyte(8'h05); wbyte(8'h03); wbyte(8'd39);
    wbyte(8'h5C);
    check("R6 mem_we", s_we, 1'b1);
    check("R6 write addr", s_addr, {3'd5, 5'd3, 6'd39});
    check("R6 write data", s_wdata, 8'h5C);
    wbyte(8'h12);
    check("R3 wrap 11 to 0", reg_of(0), 8'h12);
    check("R7 column wraps to 0", reg_of(10), 8'h00);
    check("R7 row increments", reg_of(9), 8'h04);

    // R6/R7/R5: window read with select bit clear
    start(1'b0); wbyte(8'd11);
    start(1'b1); rbyte();
    check("R6 mem_re", s_re, 1'b1);
    check("R6 read addr", s_addr, {3'd5, 5'd4, 6'd0});
    check("R5 window data", s_rd, mem_model({3'd5, 5'd4, 6'd0}));
    check("R7 column steps", reg_of(10), 8'h01);
    rbyte();
    check("R3 read wraps to reg 0", s_rd, 8'hFF);

    // R5/R8: select status, capture at read start, change inputs afterwards
    start(1'b0); wbyte(8'd0); wbyte(8'h80);
    start(1'b0); wbyte(8'd11);
    st_60hz = 1'b1; st_data_ok = 1'b0; st_sync_ok = 1'b1;
    start(1'b1);
    st_60hz = 1'b0; st_data_ok = 1'b1; st_sync_ok = 1'b0;
    rbyte();
    check("R8 status sampled at start", s_rd, 8'h81);
    check("R5 no memory read on status", s_re, 1'b0);

    // R9: write to address 11 while status selected
    start(1'b0); wbyte(8'd11); wbyte(8'h77);
    check("R9 no mem_we", s_we, 1'b0);
    check("R9 column unchanged", reg_of(10), 8'h01);
    check("R9 row unchanged", reg_of(9), 8'h04);

    // R2: out-of-range subaddress keeps the pointer
    start(1'b0); wbyte(8'd4);
    start(1'b0); wbyte(8'h20); wbyte(8'h5A);
    check("R2 pointer kept", reg_of(4), 8'h5A);
    check("R2 r0 untouched", reg_of(0), 8'h80);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule